// File: doc/BRIEF.md
# Multichannel Scaler Dwell Sequencer

This block runs a multichannel-scaler acquisition. A bank of per-channel counters accumulates hit pulses during one time slice (a dwell). At every effective dwell boundary the block captures the counts of all channels as a frame, clears the counters and advances an acquisition counter. The captured frame leaves the block as a stream of channel words with a valid/ready handshake. Acquisition ends by itself once the programmed number of time slices has been taken.

Dwell boundaries come from one of two raw sources, an internal periodic timer or an external pulse input. Either source passes through a programmable prescaler. A software strobe can also force a boundary directly. Single-cycle key strobes start, arm and stop the acquisition. An armed sequencer waits for its first boundary and only then begins counting.

Top module: `mcs_dwell_seq`

## Requirements
- R1: After reset the sequencer is idle: `mcs_active`, `mcs_armed`, `out_valid` and `overrun` are low and `acq_count` is 0.
- R2: A `key_enable` strobe while not active starts acquisition on the next cycle. It clears all channel counts, `acq_count` and `overrun`. `mcs_active` then stays high until the preset is reached or `key_disable` is strobed.
- R3: A `key_arm` strobe while idle raises `mcs_armed`. The first effective boundary then raises `mcs_active`, emits no frame and leaves `acq_count` at 0. Channels count from the following cycle.
- R4: `cfg_lne_src` = 0 selects the internal timer, which pulses every TIMER_DIV cycles counted from the start strobe. `cfg_lne_src` = 1 selects `ext_lne`. `key_lne` forces a boundary while armed or active and bypasses the prescaler.
- R5: With `cfg_prescale` = N, one effective boundary occurs per N+1 raw source pulses. N = 0 passes every pulse.
- R6: Each boundary taken while active emits one frame of NCH words. The words come out in channel order 0 to NCH-1, with the index on `out_chan` and `out_last` high on the final word. Each word holds the hits that channel counted during the slice just closed, modulo 2^CW.
- R7: Hits that arrive in the same cycle as a boundary are counted in the new slice, so no hit is lost at a boundary.
- R8: `acq_count` rises by one on every boundary taken while active. When it equals a non-zero `cfg_acq_preset`, acquisition stops and the counts are cleared. A preset of 0 runs without limit. The preset must be held while active.
- R9: A boundary taken while a frame is still being emitted sets the sticky `overrun` flag and drops the new frame. The counters are still cleared and `acq_count` still advances.
- R10: While `out_valid` is high and `out_ready` is low, `out_data` and `out_chan` hold their values.
- R11: `key_disable` returns the sequencer to idle and suppresses a boundary in the same cycle, and the channel counts are held. `key_enable` is ignored while active, `key_arm` is ignored unless idle, and `key_lne` is ignored while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_lne_src | input | 1 | Raw boundary source: 0 internal timer, 1 external pulse |
| cfg_prescale | input | PRE_W | Prescale factor N (one boundary per N+1 raw pulses) |
| cfg_acq_preset | input | ACQ_W | Number of slices to acquire, 0 = unlimited |
| key_arm | input | 1 | Arm strobe |
| key_enable | input | 1 | Enable strobe |
| key_disable | input | 1 | Disable strobe |
| key_lne | input | 1 | Software boundary strobe |
| ext_lne | input | 1 | External boundary pulse, synchronous, one cycle per pulse |
| ch_hits | input | NCH | Per-channel hit pulses, one count per cycle when high |
| out_valid | output | 1 | Stream word valid |
| out_ready | input | 1 | Stream consumer ready |
| out_data | output | CW | Channel count word |
| out_chan | output | IW | Channel index of the current word |
| out_last | output | 1 | Final word of a frame |
| acq_count | output | ACQ_W | Slices processed since start |
| mcs_active | output | 1 | Acquisition running |
| mcs_armed | output | 1 | Waiting for the first boundary |
| overrun | output | 1 | Sticky: a frame was dropped |

## Verification
The hardest situation to reach is a boundary that collides with other events in the same cycle. Such a boundary can meet a stream still draining under backpressure, the final slice, or a disable strobe. The stimulus spaces external pulses closer than a frame's length and randomises `out_ready` to force overrun. It saturates every hit input so that each slice's count must equal its length exactly. It also fires disable together with an external pulse. A cycle-level reference model predicts every output in every cycle, so any misplaced boundary shows up at once.

// File: rtl/mcs_pkg.sv
package mcs_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ARMED  = 2'd1,
        ST_ACTIVE = 2'd2
    } mcs_state_e;
endpackage

// File: rtl/mcs_lne_gen.sv
module mcs_lne_gen #(
    parameter int PRE_W     = 8,
    parameter int TIMER_DIV = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic             src_sel,
    input  logic             ext_pulse,
    input  logic             sw_lne,
    input  logic [PRE_W-1:0] prescale,
    output logic             lne
);
    localparam int TW = (TIMER_DIV > 2) ? $clog2(TIMER_DIV) : 1;
    localparam logic [TW-1:0] TMAX = TW'(TIMER_DIV - 1);

    typedef struct packed {
        logic [TW-1:0]    tmr;
        logic [PRE_W-1:0] pre;
    } gen_t;

    gen_t g_d, g_q;
    logic tick, raw, pre_hit;

    always_comb begin
        tick    = (g_q.tmr == TMAX);
        raw     = src_sel ? ext_pulse : tick;
        pre_hit = raw && (g_q.pre == prescale);
        g_d     = g_q;
        if (restart) begin
            g_d.tmr = '0;
            g_d.pre = '0;
        end else if (run) begin
            g_d.tmr = tick ? '0 : g_q.tmr + 1'b1;
            if (raw) g_d.pre = pre_hit ? '0 : g_q.pre + 1'b1;
        end
        lne = run && !restart && (pre_hit || sw_lne);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) g_q <= '0;
        else        g_q <= g_d;
    end

    // R4
    tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !restart && tick) |=> !tick);
endmodule

// File: rtl/mcs_chan_bank.sv
module mcs_chan_bank #(
    parameter int NCH = 8,
    parameter int CW  = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NCH-1:0]         hits,
    input  logic                   count_en,
    input  logic                   load_hits,
    input  logic                   clr,
    output logic [NCH-1:0][CW-1:0] counts
);
    for (genvar i = 0; i < NCH; i++) begin : g_lane
        logic [CW-1:0] c_d, c_q;

        always_comb begin
            c_d = c_q;
            if (clr)            c_d = '0;
            else if (load_hits) c_d = {{(CW-1){1'b0}}, hits[i]};
            else if (count_en)  c_d = c_q + {{(CW-1){1'b0}}, hits[i]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) c_q <= '0;
            else        c_q <= c_d;
        end

        assign counts[i] = c_q;

        // R7
        carry_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (load_hits && !clr) |=> (c_q == {{(CW-1){1'b0}}, $past(hits[i])}));
    end
endmodule

// File: rtl/mcs_frame_emit.sv
module mcs_frame_emit #(
    parameter int NCH = 8,
    parameter int CW  = 16,
    parameter int IW  = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   take,
    input  logic [NCH-1:0][CW-1:0] counts,
    input  logic                   clr_ovr,
    input  logic                   ready,
    output logic                   valid,
    output logic [CW-1:0]          data,
    output logic [IW-1:0]          chan,
    output logic                   last,
    output logic                   overrun
);
    localparam logic [IW-1:0] IMAX = IW'(NCH - 1);

    typedef struct packed {
        logic [NCH-1:0][CW-1:0] frame;
        logic [IW-1:0]          idx;
        logic                   busy;
        logic                   ovr;
    } emit_t;

    emit_t e_d, e_q;
    logic  hs;

    always_comb begin
        e_d = e_q;
        hs  = e_q.busy && ready;
        if (hs) begin
            if (e_q.idx == IMAX) begin
                e_d.busy = 1'b0;
                e_d.idx  = '0;
            end else begin
                e_d.idx = e_q.idx + 1'b1;
            end
        end
        if (take) begin
            if (e_q.busy) begin
                e_d.ovr = 1'b1;
            end else begin
                e_d.frame = counts;
                e_d.busy  = 1'b1;
                e_d.idx   = '0;
            end
        end
        if (clr_ovr) e_d.ovr = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) e_q <= '0;
        else        e_q <= e_d;
    end

    assign valid   = e_q.busy;
    assign data    = e_q.frame[e_q.idx];
    assign chan    = e_q.idx;
    assign last    = e_q.busy && (e_q.idx == IMAX);
    assign overrun = e_q.ovr;

    // R10
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !ready) |=> (valid && $stable(data) && $stable(chan)));
    // R6
    frame_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && ready && last) |=> !valid);
    // R9
    ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !clr_ovr) |=> overrun);
endmodule

// File: rtl/mcs_dwell_seq.sv
module mcs_dwell_seq #(
    parameter int NCH       = 8,
    parameter int CW        = 16,
    parameter int PRE_W     = 8,
    parameter int ACQ_W     = 16,
    parameter int TIMER_DIV = 10,
    parameter int IW        = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_lne_src,
    input  logic [PRE_W-1:0] cfg_prescale,
    input  logic [ACQ_W-1:0] cfg_acq_preset,
    input  logic             key_arm,
    input  logic             key_enable,
    input  logic             key_disable,
    input  logic             key_lne,
    input  logic             ext_lne,
    input  logic [NCH-1:0]   ch_hits,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [CW-1:0]    out_data,
    output logic [IW-1:0]    out_chan,
    output logic             out_last,
    output logic [ACQ_W-1:0] acq_count,
    output logic             mcs_active,
    output logic             mcs_armed,
    output logic             overrun
);
    import mcs_pkg::*;

    typedef struct packed {
        mcs_state_e       st;
        logic [ACQ_W-1:0] acq;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic start_en, start_arm, start, run, lne;
    logic act_lne, arm_lne, final_lne;
    logic [NCH-1:0][CW-1:0] counts;

    always_comb begin
        start_en  = key_enable && (ctl_q.st != ST_ACTIVE) && !key_disable;
        start_arm = key_arm && (ctl_q.st == ST_IDLE) && !key_disable && !key_enable;
        start     = start_en || start_arm;
        run       = (ctl_q.st != ST_IDLE) && !key_disable;
    end

    mcs_lne_gen #(.PRE_W(PRE_W), .TIMER_DIV(TIMER_DIV)) u_gen (
        .clk(clk), .rst_n(rst_n), .run(run), .restart(start),
        .src_sel(cfg_lne_src), .ext_pulse(ext_lne), .sw_lne(key_lne),
        .prescale(cfg_prescale), .lne(lne)
    );

    always_comb begin
        act_lne   = lne && (ctl_q.st == ST_ACTIVE);
        arm_lne   = lne && (ctl_q.st == ST_ARMED);
        final_lne = act_lne && (cfg_acq_preset != '0) &&
                    ((ctl_q.acq + 1'b1) == cfg_acq_preset);
        ctl_d = ctl_q;
        if (key_disable) begin
            ctl_d.st = ST_IDLE;
        end else if (start_en) begin
            ctl_d.st  = ST_ACTIVE;
            ctl_d.acq = '0;
        end else if (start_arm) begin
            ctl_d.st  = ST_ARMED;
            ctl_d.acq = '0;
        end else if (arm_lne) begin
            ctl_d.st = ST_ACTIVE;
        end else if (act_lne) begin
            ctl_d.acq = ctl_q.acq + 1'b1;
            if (final_lne) ctl_d.st = ST_IDLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.st  <= ST_IDLE;
            ctl_q.acq <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    mcs_chan_bank #(.NCH(NCH), .CW(CW)) u_bank (
        .clk(clk), .rst_n(rst_n), .hits(ch_hits),
        .count_en((ctl_q.st == ST_ACTIVE) && !key_disable),
        .load_hits(act_lne && !final_lne),
        .clr(start || arm_lne || final_lne),
        .counts(counts)
    );

    mcs_frame_emit #(.NCH(NCH), .CW(CW), .IW(IW)) u_emit (
        .clk(clk), .rst_n(rst_n), .take(act_lne), .counts(counts),
        .clr_ovr(start), .ready(out_ready), .valid(out_valid),
        .data(out_data), .chan(out_chan), .last(out_last), .overrun(overrun)
    );

    assign acq_count  = ctl_q.acq;
    assign mcs_active = (ctl_q.st == ST_ACTIVE);
    assign mcs_armed  = (ctl_q.st == ST_ARMED);

    // R8
    acq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (acq_count == $past(acq_count) ||
                  acq_count == $past(acq_count) + 1'b1 || acq_count == '0));
    // R8
    preset_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mcs_active && cfg_acq_preset != '0 && $stable(cfg_acq_preset))
            |-> (acq_count < cfg_acq_preset));
    // R11
    disable_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        key_disable |=> (!mcs_active && !mcs_armed));
    // R3
    arm_no_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mcs_armed && !out_valid) |=> !out_valid);
endmodule

// File: tb/sim_mcs_dwell_seq.sv
`timescale 1ns/1ps
module sim_mcs_dwell_seq;
    localparam int NCH = 8, CW = 16, PRE_W = 8, ACQ_W = 16, TDIV = 10;
    localparam int IW = $clog2(NCH);

    logic clk = 1'b0, rst_n = 1'b0;
    logic cfg_lne_src = 1'b1;
    logic [PRE_W-1:0] cfg_prescale = '0;
    logic [ACQ_W-1:0] cfg_acq_preset = '0;
    logic key_arm = 0, key_enable = 0, key_disable = 0, key_lne = 0, ext_lne = 0;
    logic [NCH-1:0] ch_hits = '0;
    logic out_ready = 1'b1;
    logic out_valid, out_last, mcs_active, mcs_armed, overrun;
    logic [CW-1:0] out_data;
    logic [IW-1:0] out_chan;
    logic [ACQ_W-1:0] acq_count;

    always #4 clk = ~clk;

    mcs_dwell_seq #(.NCH(NCH), .CW(CW), .PRE_W(PRE_W), .ACQ_W(ACQ_W),
                    .TIMER_DIV(TDIV)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_lne_src(cfg_lne_src),
        .cfg_prescale(cfg_prescale), .cfg_acq_preset(cfg_acq_preset),
        .key_arm(key_arm), .key_enable(key_enable), .key_disable(key_disable),
        .key_lne(key_lne), .ext_lne(ext_lne), .ch_hits(ch_hits),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_chan(out_chan), .out_last(out_last), .acq_count(acq_count),
        .mcs_active(mcs_active), .mcs_armed(mcs_armed), .overrun(overrun)
    );

    int n_checks = 0, n_fail = 0, cycles = 0;
    string phase = "R1";
    bit hit_all = 0, rdy_rand = 0;

    // reference model state
    int m_st = 0, m_acq = 0, m_tmr = 0, m_pre = 0, m_idx = 0;
    bit m_ovr = 0;
    int m_cnt[NCH];
    int fq[$];

    task automatic check(string tag, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s (phase %s) t=%0t actual=%0d expected=%0d", tag, phase, $time, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_acq = 0; m_tmr = 0; m_pre = 0; m_idx = 0; m_ovr = 0;
            fq.delete();
            for (int i = 0; i < NCH; i++) m_cnt[i] = 0;
        end else begin
            automatic bit busy0 = fq.size() > 0;
            automatic bit tick = (m_tmr == TDIV - 1);
            automatic bit raw = cfg_lne_src ? ext_lne : tick;
            automatic bit phit = raw && (m_pre == int'(cfg_prescale));
            automatic bit runm = (m_st != 0) && !key_disable;
            automatic bit s_en = key_enable && m_st != 2 && !key_disable;
            automatic bit s_arm = key_arm && m_st == 0 && !key_disable && !key_enable;
            automatic bit lne = runm && !(s_en || s_arm) && (phit || key_lne);
            if (busy0 && out_ready) begin
                void'(fq.pop_front());
                m_idx = (m_idx == NCH - 1) ? 0 : m_idx + 1;
            end
            if (s_en || s_arm) begin
                m_tmr = 0; m_pre = 0;
            end else if (runm) begin
                m_tmr = tick ? 0 : m_tmr + 1;
                if (raw) m_pre = phit ? 0 : m_pre + 1;
            end
            if (key_disable) m_st = 0;
            else if (s_en || s_arm) begin
                m_st = s_en ? 2 : 1; m_acq = 0; m_ovr = 0;
                for (int i = 0; i < NCH; i++) m_cnt[i] = 0;
            end else if (m_st == 1 && lne) begin
                m_st = 2;
                for (int i = 0; i < NCH; i++) m_cnt[i] = 0;
            end else if (m_st == 2) begin
                if (lne) begin
                    if (busy0) m_ovr = 1;
                    else for (int i = 0; i < NCH; i++) fq.push_back(m_cnt[i]);
                    m_acq = (m_acq + 1) % (1 << ACQ_W);
                    if (cfg_acq_preset != 0 && m_acq == int'(cfg_acq_preset)) begin
                        m_st = 0;
                        for (int i = 0; i < NCH; i++) m_cnt[i] = 0;
                    end else
                        for (int i = 0; i < NCH; i++) m_cnt[i] = int'(ch_hits[i]);
                end else
                    for (int i = 0; i < NCH; i++)
                        m_cnt[i] = (m_cnt[i] + int'(ch_hits[i])) % (1 << CW);
            end
        end
    end

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        cycles++;
        check("R2 mcs_active", int'(mcs_active), int'(m_st == 2));
        check("R3 mcs_armed", int'(mcs_armed), int'(m_st == 1));
        check("R8 acq_count", int'(acq_count), m_acq);
        check("R9 overrun", int'(overrun), int'(m_ovr));
        check("R6 out_valid", int'(out_valid), int'(fq.size() > 0));
        if (fq.size() > 0 && out_valid) begin
            check("R6 out_data", int'(out_data), fq[0]);
            check("R6 out_chan", int'(out_chan), m_idx);
            check("R6 out_last", int'(out_last), int'(m_idx == NCH - 1));
        end
        if (cycles > 100000) begin
            n_fail++;
            $display("FAIL watchdog expired in phase %s", phase);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    // background stimulus: hits and ready
    always @(negedge clk) begin
        ch_hits <= hit_all ? '1 : NCH'($urandom);
        out_ready <= rdy_rand ? 1'($urandom) : 1'b1;
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic run_ext(int period, int n);
        repeat (n) begin
            cyc(period - 1);
            ext_lne = 1; cyc(1); ext_lne = 0;
        end
    endtask

    task automatic go(input bit arm_only);
        if (arm_only) key_arm = 1; else key_enable = 1;
        cyc(1);
        key_arm = 0; key_enable = 0;
    endtask

    initial begin
        cyc(3);
        phase = "R1";
        check("R1 reset active", int'(mcs_active), 0);
        check("R1 reset valid", int'(out_valid), 0);
        check("R1 reset acq", int'(acq_count), 0);
        check("R1 reset overrun", int'(overrun), 0);
        rst_n = 1; cyc(4);

        phase = "R2"; cfg_lne_src = 1; cfg_prescale = 0; cfg_acq_preset = 4;
        go(0); run_ext(20, 5); cyc(20);

        phase = "R4"; cfg_lne_src = 0; cfg_acq_preset = 3;
        go(0); cyc(60);

        phase = "R5"; cfg_prescale = 2; cfg_acq_preset = 2;
        go(0); cyc(90);
        cfg_lne_src = 1; cfg_prescale = 1; cfg_acq_preset = 3;
        go(0); run_ext(15, 7); cyc(20);

        phase = "R3"; cfg_prescale = 0; cfg_acq_preset = 2;
        go(1); cyc(10); run_ext(20, 3); cyc(20);

        phase = "R10"; rdy_rand = 1; cfg_acq_preset = 4;
        go(0); run_ext(25, 5); cyc(40); rdy_rand = 0;

        phase = "R9"; cfg_acq_preset = 6;
        go(0); run_ext(3, 7); cyc(20);

        phase = "R7"; hit_all = 1; cfg_acq_preset = 3;
        go(0); run_ext(12, 4); cyc(20); hit_all = 0;

        phase = "R11"; cfg_acq_preset = 0;
        go(0); run_ext(15, 2);
        go(0); go(1);
        key_lne = 1; cyc(1); key_lne = 0; cyc(12);
        ext_lne = 1; key_disable = 1; cyc(1); ext_lne = 0; key_disable = 0;
        cyc(15);
        key_lne = 1; cyc(1); key_lne = 0; cyc(15);

        phase = "R8"; cfg_lne_src = 0; cfg_acq_preset = 0;
        go(0); cyc(85);
        key_disable = 1; cyc(1); key_disable = 0; cyc(20);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule